// File: doc/BRIEF.md
# Decade-Step Pulse Divider

This block counts rising edges of a pulse or square-wave input, `in_sig`, and divides it by a power of ten chosen through a configuration byte. The ratio comes from a three-bit code and runs from one up to one million. At ratio one the input is passed straight to the output. At every larger ratio the output is a registered signal with a 50% duty cycle, measured in input periods. The divider is a chain of modulo-10 digit stages. The code picks which stage's value drives the output.

A mode bit chooses between two modes. In free-running mode the block divides continuously. In one-shot mode it counts only after a start strobe, produces one divided period, and then holds idle and low. A change to the low configuration nibble clears every stage, so no shortened period ever reaches the output. A synchronous clear input does the same on demand. The upper nibble of the configuration byte has no effect here, since it holds option, spare and identity bits that other logic uses.

Top module: `decade_div`

## Requirements
- R1: With ratio code `cfg_byte[2:0]` equal to 3'b000 or 3'b111, `div_out` equals `in_sig` combinationally in both modes, starting the cycle after the code is registered.
- R2: With code c in 1..6 the ratio is R = 10^c. A counted edge is a clock edge at which `in_sig` is 1 and was 0 at the previous clock edge. After K counted edges since the last clear, `div_out` is 1 exactly when (K mod R) >= R/2, updated on the clock edge that counts.
- R3: Bits 7:4 of `cfg_byte` have no effect on counting or on the output.
- R4: When `cfg_byte[3:0]` differs from the value registered at the previous clock edge, that edge clears all digit stages and drives the divided output low. An input edge in that cycle is not counted, and the new setting applies from the next edge.
- R5: With mode bit `cfg_byte[3]` = 1 (one-shot), no edge is counted until `start` is seen high at a clock edge. That edge clears the stages and arms the block. After R counted edges the block disarms, the output is low, and counting stops.
- R6: A `start` while armed restarts the period from zero. In free-running mode (`cfg_byte[3]` = 0) `start` has no effect.
- R7: `clr` high at a clock edge clears all stages, disarms the block and drives the divided output low. It takes priority over `start` and over counting.
- R8: While `rst_n` is low, all state is cleared asynchronously and the registered code is 3'b000. Release is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the divider |
| cfg_byte | input | 8 | Bits 2:0 ratio code, bit 3 one-shot mode, bits 7:4 ignored |
| start | input | 1 | One-shot start strobe |
| in_sig | input | 1 | Pulse or square-wave input to divide |
| div_out | output | 1 | Divided output, or `in_sig` at ratio one |

## Verification
The assertions assume that `in_sig`, `start`, `clr` and `cfg_byte` are synchronous to `clk`. They also assume that an input pulse lasts at least one clock high and one clock low, so that each pulse produces exactly one counted edge. The stimulus changes every input only just after a falling clock edge, and it builds input waveforms from whole clock cycles: regular, uneven and single-cycle high and low phases. Configuration changes, clears and start strobes are placed on cycles that also carry an input edge. This confirms that the dropped edge is never counted.

// File: rtl/decade_div_pkg.sv
package decade_div_pkg;

  localparam int DIGIT_W  = 4;
  localparam int DIGIT_MAX = 9;
  localparam int DIGIT_HALF = 5;
  localparam int CODE_W   = 3;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Ratio codes of zero, or beyond the number of stages, mean divide-by-one.
  function automatic logic is_bypass(input logic [CODE_W-1:0] code, input int n_stages);
    return (code == '0) || (int'(code) > n_stages);
  endfunction

endpackage

// File: rtl/decade_div_rst_sync.sv
module decade_div_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/decade_div_edge.sv
module decade_div_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic in_sig,
  output logic rise
);

  logic in_q;

  assign rise = in_sig & ~in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0;
    end else begin
      in_q <= in_sig;
    end
  end

endmodule

// File: rtl/decade_div_stage.sv
module decade_div_stage
  import decade_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   inc,
  output digit_t cnt_q,
  output digit_t cnt_nxt,
  output logic   carry
);

  logic en;

  always_comb begin
    carry   = inc & (cnt_q == digit_t'(DIGIT_MAX));
    cnt_nxt = cnt_q;
    if (clr) begin
      cnt_nxt = '0;
    end else if (inc) begin
      cnt_nxt = carry ? '0 : cnt_q + digit_t'(1);
    end
  end

  assign en = clr | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/decade_div_ctrl.sv
module decade_div_ctrl
  import decade_div_pkg::*;
#(
  parameter int CFG_W = CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CFG_W-1:0] cfg_lo,
  input  logic             start,
  input  logic             rise,
  input  logic             carry_sel,
  output logic [CFG_W-1:0] cfg_q,
  output logic             armed_q,
  output logic             stage_clr,
  output logic             count_en
);

  logic chg;
  logic oneshot;
  logic start_hit;
  logic run;
  logic armed_d;

  always_comb begin
    chg       = (cfg_lo != cfg_q);
    oneshot   = cfg_q[CFG_W-1];
    start_hit = start & oneshot & ~chg & ~clr;
    run       = ~oneshot | armed_q;
    stage_clr = clr | chg | start_hit;
    count_en  = rise & run & ~stage_clr;

    armed_d = armed_q;
    if (clr || chg) begin
      armed_d = 1'b0;
    end else if (start_hit) begin
      armed_d = 1'b1;
    end else if (oneshot && count_en && carry_sel) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_lo;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/decade_div.sv
module decade_div
  import decade_div_pkg::*;
#(
  parameter int NUM_STAGES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [7:0] cfg_byte,
  input  logic       start,
  input  logic       in_sig,
  output logic       div_out
);

  localparam int CFG_W  = CODE_W + 1;
  localparam int FLAT_W = NUM_STAGES * DIGIT_W;

  logic             rst_sync_n;
  logic             rise;
  logic [CFG_W-1:0] cfg_q;
  logic             armed_q;
  logic             stage_clr;
  logic             count_en;
  logic             carry_sel;
  logic             bypass_q;
  logic             tap_hi;
  logic             div_d;
  logic             div_q;
  logic [CODE_W-1:0] code_q;
  logic             unused_cfg_hi;

  digit_t           cnt_q   [NUM_STAGES];
  digit_t           cnt_nxt [NUM_STAGES];
  logic [NUM_STAGES:0] inc;
  logic [FLAT_W-1:0] cnt_flat;

  assign unused_cfg_hi = ^cfg_byte[7:CFG_W];

  decade_div_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  decade_div_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .in_sig (in_sig),
    .rise   (rise)
  );

  decade_div_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (clr),
    .cfg_lo    (cfg_byte[CFG_W-1:0]),
    .start     (start),
    .rise      (rise),
    .carry_sel (carry_sel),
    .cfg_q     (cfg_q),
    .armed_q   (armed_q),
    .stage_clr (stage_clr),
    .count_en  (count_en)
  );

  assign inc[0] = count_en;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    decade_div_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr     (stage_clr),
      .inc     (inc[k]),
      .cnt_q   (cnt_q[k]),
      .cnt_nxt (cnt_nxt[k]),
      .carry   (inc[k+1])
    );
    assign cnt_flat[k*DIGIT_W +: DIGIT_W] = cnt_q[k];
  end

  assign code_q   = cfg_q[CODE_W-1:0];
  assign bypass_q = is_bypass(code_q, NUM_STAGES);

  // Tap selection: code c drives the output from stage c-1.
  always_comb begin
    tap_hi    = 1'b0;
    carry_sel = 1'b0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (!bypass_q && (int'(code_q) == k + 1)) begin
        tap_hi    = (cnt_nxt[k] >= digit_t'(DIGIT_HALF));
        carry_sel = inc[k+1];
      end
    end
  end

  always_comb begin
    div_d = 1'b0;
    if (!stage_clr && !bypass_q) begin
      div_d = tap_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q <= 1'b0;
    end else begin
      div_q <= div_d;
    end
  end

  assign div_out = bypass_q ? in_sig : div_q;

endmodule

// File: rtl/decade_div_chk.sv
module decade_div_chk
  import decade_div_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int CFG_W = CODE_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          start,
  input  logic [CFG_W-1:0]              cfg_lo,
  input  logic [CFG_W-1:0]              cfg_q,
  input  logic                          armed_q,
  input  logic                          div_q,
  input  logic [NUM_STAGES*DIGIT_W-1:0] cnt_flat
);

  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_flat == '0) && !armed_q && !div_q);

  // R4
  cfg_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lo != cfg_q) |=> (cnt_flat == '0) && !div_q);

  // R5
  idle_shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_W-1] && !armed_q && !start && !clr && (cfg_lo == cfg_q)) |=> $stable(cnt_flat));

  // R5
  idle_shot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_W-1] && !armed_q) |-> !div_q);

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_digit
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[k*DIGIT_W +: DIGIT_W] <= DIGIT_W'(DIGIT_MAX));
  end

endmodule

bind decade_div decade_div_chk #(.NUM_STAGES(NUM_STAGES), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .clr      (clr),
  .start    (start),
  .cfg_lo   (cfg_byte[CFG_W-1:0]),
  .cfg_q    (cfg_q),
  .armed_q  (armed_q),
  .div_q    (div_q),
  .cnt_flat (cnt_flat)
);

// File: tb/decade_div_tb.sv
module decade_div_tb;

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic [7:0] cfg_byte;
  logic       start;
  logic       in_sig;
  logic       div_out;

  int    n_vec;
  int    n_bad;
  string cur_req;
  bit    checking;

  // behavioural reference state
  logic [3:0] m_cfg;
  longint     m_cnt;
  bit         m_armed;
  bit         m_outq;
  bit         m_prev;

  decade_div u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cfg_byte (cfg_byte),
    .start    (start),
    .in_sig   (in_sig),
    .div_out  (div_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint ratio_of(input logic [2:0] code);
    longint r = 1;
    if (code == 3'd0 || code == 3'd7) return 1;
    for (int i = 0; i < int'(code); i++) r = r * 10;
    return r;
  endfunction

  function automatic bit byp_of(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd7);
  endfunction

  task automatic model_reset();
    m_cfg = 4'd0; m_cnt = 0; m_armed = 0; m_outq = 0; m_prev = 0;
  endtask

  task automatic model_tick();
    bit     chg, mode, byp, edg, sh;
    longint r;
    chg  = (cfg_byte[3:0] != m_cfg);
    mode = m_cfg[3];
    byp  = byp_of(m_cfg[2:0]);
    r    = ratio_of(m_cfg[2:0]);
    edg  = in_sig && !m_prev;
    sh   = start && mode && !chg && !clr;
    if (clr || chg) begin
      m_cnt = 0; m_armed = 0; m_outq = 0;
    end else if (sh) begin
      m_cnt = 0; m_armed = 1; m_outq = 0;
    end else if (edg && (!mode || m_armed)) begin
      m_cnt++;
      if (!byp) begin
        if (m_cnt == r) begin
          m_cnt = 0;
          if (mode) m_armed = 0;
        end
        m_outq = (m_cnt >= r / 2);
      end
    end
    m_prev = in_sig;
    m_cfg  = cfg_byte[3:0];
  endtask

  task automatic compare();
    bit exp;
    exp = byp_of(m_cfg[2:0]) ? in_sig : m_outq;
    n_vec++;
    if (div_out !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t div_out actual=%b expected=%b", cur_req, $time, div_out, exp);
    end
  endtask

  // one clock with the given inputs, then a check after the falling edge
  task automatic step(input logic i, input logic [7:0] c, input logic s, input logic k);
    in_sig = i; cfg_byte = c; start = s; clr = k;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    #1;
    if (checking) compare();
  endtask

  // n input periods, hi cycles high and lo cycles low, other inputs held
  task automatic wave(input int n, input int hi, input int lo, input logic [7:0] c);
    for (int p = 0; p < n; p++) begin
      for (int h = 0; h < hi; h++) step(1'b1, c, 1'b0, 1'b0);
      for (int l = 0; l < lo; l++) step(1'b0, c, 1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    checking = 0;
    in_sig = 0; cfg_byte = 8'h00; start = 0; clr = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    checking = 1;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; checking = 0;
    cur_req = "R8";
    do_reset();
    // R8: reset state, idle then code 1 registered: output low
    repeat (4) step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h01, 1'b0, 1'b0);
    step(1'b0, 8'h01, 1'b0, 1'b0);

    // R1: bypass with code 000 and code 111, both modes
    cur_req = "R1";
    step(1'b0, 8'h00, 1'b0, 1'b0);
    wave(6, 1, 2, 8'h00);
    wave(5, 3, 1, 8'h07);
    wave(5, 2, 2, 8'h0F);
    step(1'b1, 8'h0F, 1'b1, 1'b0);
    wave(4, 1, 1, 8'h0F);

    // R2: free-running ratios with several waveforms
    cur_req = "R2";
    wave(35, 1, 1, 8'h01);
    wave(250, 2, 3, 8'h02);
    wave(2100, 1, 1, 8'h03);
    wave(10050, 1, 1, 8'h04);
    wave(600, 1, 1, 8'h05);
    wave(300, 1, 1, 8'h06);

    // R3: upper nibble changes mid-count are ignored
    cur_req = "R3";
    wave(23, 1, 1, 8'h02);
    wave(20, 1, 1, 8'hF2);
    wave(20, 1, 1, 8'h52);
    wave(20, 1, 1, 8'hA2);

    // R4: ratio change with an input edge on the change cycle
    cur_req = "R4";
    wave(37, 1, 1, 8'h02);
    step(1'b1, 8'h01, 1'b0, 1'b0);
    step(1'b0, 8'h01, 1'b0, 1'b0);
    wave(13, 1, 1, 8'h01);
    wave(3, 1, 1, 8'h02);
    step(1'b1, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    wave(3, 1, 1, 8'h02);

    // R5: one-shot, edges before start are not counted
    cur_req = "R5";
    wave(12, 1, 1, 8'h09);
    step(1'b1, 8'h09, 1'b1, 1'b0);
    step(1'b0, 8'h09, 1'b0, 1'b0);
    wave(15, 1, 1, 8'h09);
    step(1'b0, 8'h0A, 1'b1, 1'b0);
    step(1'b0, 8'h0A, 1'b1, 1'b0);
    wave(130, 2, 1, 8'h0A);

    // R6: retrigger while armed, start ignored when free-running
    cur_req = "R6";
    step(1'b0, 8'h09, 1'b1, 1'b0);
    step(1'b0, 8'h09, 1'b1, 1'b0);
    wave(7, 1, 1, 8'h09);
    step(1'b1, 8'h09, 1'b1, 1'b0);
    step(1'b0, 8'h09, 1'b0, 1'b0);
    wave(12, 1, 1, 8'h09);
    wave(7, 1, 1, 8'h01);
    step(1'b1, 8'h01, 1'b1, 1'b0);
    step(1'b0, 8'h01, 1'b1, 1'b0);
    wave(8, 1, 1, 8'h01);

    // R7: clear mid-period, clear beats start
    cur_req = "R7";
    wave(7, 1, 1, 8'h01);
    step(1'b1, 8'h01, 1'b0, 1'b1);
    step(1'b0, 8'h01, 1'b0, 1'b0);
    wave(12, 1, 1, 8'h01);
    step(1'b0, 8'h09, 1'b0, 1'b0);
    step(1'b0, 8'h09, 1'b1, 1'b0);
    wave(6, 1, 1, 8'h09);
    step(1'b0, 8'h09, 1'b1, 1'b1);
    wave(6, 1, 1, 8'h09);

    // R8: asynchronous reset in the middle of a count
    cur_req = "R8";
    wave(57, 1, 1, 8'h02);
    do_reset();
    repeat (3) step(1'b0, 8'h00, 1'b0, 1'b0);
    wave(30, 1, 1, 8'h01);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule